// File: doc/BRIEF.md
# Multichannel PWM Timer Bank

This block holds eight independent 32-bit pulse-width timers behind a simple APB-style register port. Each channel has a counter, a duty compare value, a period compare value and an 8-bit control word. It drives one PWM pin and one interrupt line. The counter advances on every bus clock or on a chosen edge of a per-channel external clock, which is first passed through a synchronizer. It wraps after the programmed period, and the output polarity is fixed: the pin is low at the start of each period and goes high once the counter reaches the duty value.

Software programs a channel by stopping it (control written to zero), loading duty, period and counter, and then setting enable together with output enable. A channel can run once and stop by itself, and it can raise an interrupt at each period end. The interrupt stays pending until software clears it.

Top module: `pwm_timer_bank`

## Requirements
- R1: Channel i is reached at byte address {i[2], 9'b0, i[1:0], 4'b0}, with i[2] on bit 15 and i[1:0] on bits 5:4. Inside the window, bits 3:2 select the register: 0 counter, 1 duty (high-reference), 2 period (low-reference), 3 control. An address with any of bits 14:6 set reaches no register and reads 0. Writes land in the access phase (psel, penable, pwrite all high).
- R2: The control word bits are: 0 enable, 1 external-clock select, 2 count on falling edge, 3 output enable, 4 single-run, 5 interrupt enable, 6 interrupt pending, 7 counter clear. Bits 31:8 are not stored and read 0.
- R3: While enable is 1 and external-clock select is 0, the counter advances by one on every clock. A tick that finds counter+1 >= period returns it to 0. The period is therefore `period` clocks, and a period of 0 or 1 gives 1 clock.
- R4: The PWM pin is high exactly when output enable is 1 and counter >= duty. Over one full period it is high for period-duty clocks when duty < period, and 0 clocks otherwise.
- R5: A bus write to the counter register loads the written value on that clock edge and takes priority over counting.
- R6: Writing 0 to the control register stops the channel. From the next cycle the counter holds, the pin is low and the interrupt line is low.
- R7: In single-run mode, the tick that ends the first period clears enable, and the counter then holds at 0.
- R8: At each period end with interrupt enable set, the pending bit becomes 1. The interrupt line equals pending AND interrupt enable. A control write with bit 6 at 0 clears pending, and a control write with bit 6 at 1 cannot set it.
- R9: While counter clear is 1, the counter is 0 from the following clock onward, whatever the other inputs.
- R10: With external-clock select set, the counter advances once per rising edge of its external clock input, or once per falling edge if bit 2 is set. The input passes through two synchronizing flops, and no tick comes from the bus clock.
- R11: After reset, all registers are 0 and every PWM pin and interrupt line is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and counter clock |
| rstN | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 16 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational from the addressed register |
| extClk | input | 8 | Per-channel external count clock, asynchronous |
| pwmOut | output | 8 | Per-channel PWM pin |
| irq | output | 8 | Per-channel interrupt line |

## Verification
A register write takes effect on the clock edge that closes its access phase, so readback and pin changes are sampled on the falling edge that follows. After an enabling control write, the counter is 0 for one sample and then steps once per clock. The bench therefore counts pin-high samples over a whole number of periods, starting at that first sample, and expects the interrupt line to rise exactly `period` samples after the enable write. An external clock edge reaches the counter three bus clocks after the pin moves, so the bench holds each level for four clocks and waits before it reads the count.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

  localparam int CTRL_W  = 8;

  // Control word bit positions
  localparam int CB_EN   = 0;
  localparam int CB_ECLK = 1;
  localparam int CB_NEG  = 2;
  localparam int CB_OE   = 3;
  localparam int CB_ONCE = 4;
  localparam int CB_IEN  = 5;
  localparam int CB_PEND = 6;
  localparam int CB_CLR  = 7;

  typedef enum logic [1:0] {
    RS_CNT  = 2'd0,
    RS_HI   = 2'd1,
    RS_LO   = 2'd2,
    RS_CTRL = 2'd3
  } regSel_e;

  // Strobes from channel control to channel datapath
  typedef struct packed {
    logic tick;
    logic clear;
    logic loadCnt;
    logic loadHi;
    logic loadLo;
    logic outEn;
  } chanStrobe_t;

endpackage

// File: rtl/pwm_chan_dp.sv
module pwm_chan_dp
  import pwm_bank_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  chanStrobe_t      strb,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] cntQ,
  output logic [CNT_W-1:0] hiQ,
  output logic [CNT_W-1:0] loQ,
  output logic             periodEnd,
  output logic             pwmOut
);

  logic [CNT_W:0] cntInc;
  logic           atEnd;

  assign cntInc    = {1'b0, cntQ} + {{CNT_W{1'b0}}, 1'b1};
  assign atEnd     = cntInc >= {1'b0, loQ};
  assign periodEnd = strb.tick & ~strb.clear & ~strb.loadCnt & atEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (strb.clear) begin
      cntQ <= '0;
    end else if (strb.loadCnt) begin
      cntQ <= wrData;
    end else if (strb.tick) begin
      cntQ <= atEnd ? '0 : cntInc[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiQ <= '0;
      loQ <= '0;
    end else begin
      if (strb.loadHi) hiQ <= wrData;
      if (strb.loadLo) loQ <= wrData;
    end
  end

  // Inverted polarity: low before the duty match, high after it
  assign pwmOut = strb.outEn & (cntQ >= hiQ);

endmodule

// File: rtl/pwm_chan_ctrl.sv
module pwm_chan_ctrl
  import pwm_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrCtrl,
  input  logic              wrCnt,
  input  logic              wrHi,
  input  logic              wrLo,
  input  logic [CTRL_W-1:0] wrData,
  input  logic              extClk,
  input  logic              periodEnd,
  output chanStrobe_t       strb,
  output logic [CTRL_W-1:0] ctrlQ,
  output logic              irq
);

  logic [2:0]        syncQ;
  logic              extRise;
  logic              extFall;
  logic              extHit;
  logic [CTRL_W-1:0] ctrlNext;

  // Two synchronizing flops, the third stage only remembers the previous level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[1:0], extClk};
  end

  assign extRise = syncQ[1] & ~syncQ[2];
  assign extFall = ~syncQ[1] & syncQ[2];
  assign extHit  = ctrlQ[CB_NEG] ? extFall : extRise;

  always_comb begin
    ctrlNext = ctrlQ;
    if (wrCtrl) begin
      ctrlNext          = wrData;
      ctrlNext[CB_PEND] = wrData[CB_PEND] & ctrlQ[CB_PEND];
    end
    if (periodEnd && ctrlQ[CB_IEN])  ctrlNext[CB_PEND] = 1'b1;
    if (periodEnd && ctrlQ[CB_ONCE]) ctrlNext[CB_EN]   = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlQ <= '0;
    else       ctrlQ <= ctrlNext;
  end

  always_comb begin
    strb.tick    = ctrlQ[CB_EN] & (ctrlQ[CB_ECLK] ? extHit : 1'b1);
    strb.clear   = ctrlQ[CB_CLR];
    strb.loadCnt = wrCnt;
    strb.loadHi  = wrHi;
    strb.loadLo  = wrLo;
    strb.outEn   = ctrlQ[CB_OE];
  end

  assign irq = ctrlQ[CB_PEND] & ctrlQ[CB_IEN];

endmodule

// File: rtl/pwm_timer_bank.sv
module pwm_timer_bank
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [CNT_W-1:0]  pwdata,
  output logic [CNT_W-1:0]  prdata,
  input  logic [NUM_CH-1:0] extClk,
  output logic [NUM_CH-1:0] pwmOut,
  output logic [NUM_CH-1:0] irq
);

  localparam int IDX_W = 3;

  logic [IDX_W-1:0] chIdx;
  regSel_e          regSel;
  logic             inWin;
  logic             wrEn;
  logic             unusedAddr;

  logic [NUM_CH-1:0][CNT_W-1:0]  cntVec;
  logic [NUM_CH-1:0][CNT_W-1:0]  hiVec;
  logic [NUM_CH-1:0][CNT_W-1:0]  loVec;
  logic [NUM_CH-1:0][CTRL_W-1:0] ctrlVec;

  // Sparse map: index bit 2 on the top address bit, bits 1:0 pick a 16-byte window
  assign chIdx      = {paddr[ADDR_W-1], paddr[5:4]};
  assign regSel     = regSel_e'(paddr[3:2]);
  assign inWin      = (paddr[ADDR_W-2:6] == '0) && (int'(chIdx) < NUM_CH);
  assign wrEn       = psel & penable & pwrite & inWin;
  assign unusedAddr = ^paddr[1:0];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic        chHit;
    logic        periodEnd;
    chanStrobe_t strb;

    assign chHit = wrEn && (int'(chIdx) == i);

    pwm_chan_ctrl i_ctrl (
      .clk       (clk),
      .rstN      (rstN),
      .wrCtrl    (chHit && regSel == RS_CTRL),
      .wrCnt     (chHit && regSel == RS_CNT),
      .wrHi      (chHit && regSel == RS_HI),
      .wrLo      (chHit && regSel == RS_LO),
      .wrData    (pwdata[CTRL_W-1:0]),
      .extClk    (extClk[i]),
      .periodEnd (periodEnd),
      .strb      (strb),
      .ctrlQ     (ctrlVec[i]),
      .irq       (irq[i])
    );

    pwm_chan_dp #(.CNT_W(CNT_W)) i_dp (
      .clk       (clk),
      .rstN      (rstN),
      .strb      (strb),
      .wrData    (pwdata),
      .cntQ      (cntVec[i]),
      .hiQ       (hiVec[i]),
      .loQ       (loVec[i]),
      .periodEnd (periodEnd),
      .pwmOut    (pwmOut[i])
    );
  end

  always_comb begin
    prdata = '0;
    if (psel && !pwrite && inWin) begin
      unique case (regSel)
        RS_CNT:  prdata = cntVec[chIdx];
        RS_HI:   prdata = hiVec[chIdx];
        RS_LO:   prdata = loVec[chIdx];
        RS_CTRL: prdata = {{(CNT_W-CTRL_W){1'b0}}, ctrlVec[chIdx]};
        default: prdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/pwm_timer_bank_chk.sv
module pwm_timer_bank_chk #(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 32
) (
  input logic                           clk,
  input logic                           rstN,
  input logic                           psel,
  input logic                           penable,
  input logic                           pwrite,
  input logic [15:0]                    paddr,
  input logic [CNT_W-1:0]               pwdata,
  input logic [NUM_CH-1:0]              pwmOut,
  input logic [NUM_CH-1:0]              irq,
  input logic [NUM_CH-1:0][CNT_W-1:0]   cntVec,
  input logic [NUM_CH-1:0][7:0]         ctrlVec
);

  logic wrAny;
  logic unusedChk;
  assign wrAny     = psel & penable & pwrite;
  assign unusedChk = ^{paddr[1:0], pwdata[CNT_W-1:8]};

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    localparam logic [2:0] IDX = 3'(i);
    logic ctrlZeroWr;
    assign ctrlZeroWr = wrAny && paddr[15] == IDX[2] && paddr[5:4] == IDX[1:0]
                        && paddr[14:6] == '0 && paddr[3:2] == 2'd3
                        && pwdata[7:0] == 8'd0;

    a_r6_stop_quiet: assert property (@(posedge clk) disable iff (!rstN)
      ctrlZeroWr |=> (!pwmOut[i] && !irq[i]));

    a_r6_hold_when_off: assert property (@(posedge clk) disable iff (!rstN)
      (!ctrlVec[i][0] && !ctrlVec[i][7] && !wrAny) |=> $stable(cntVec[i]));

    a_r3_step_or_wrap: assert property (@(posedge clk) disable iff (!rstN)
      (ctrlVec[i][0] && !ctrlVec[i][1] && !ctrlVec[i][7] && !wrAny) |=>
        ((cntVec[i] == $past(cntVec[i]) + CNT_W'(1)) || (cntVec[i] == '0)));

    a_r9_clear_holds_zero: assert property (@(posedge clk) disable iff (!rstN)
      (ctrlVec[i][7] && !wrAny) |=> (cntVec[i] == '0));

    a_r7_single_stop_at_zero: assert property (@(posedge clk) disable iff (!rstN)
      (ctrlVec[i][0] && ctrlVec[i][4] && !wrAny) ##1 !ctrlVec[i][0] |-> (cntVec[i] == '0));
  end

endmodule

bind pwm_timer_bank pwm_timer_bank_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) i_chk (
  .clk     (clk),
  .rstN    (rstN),
  .psel    (psel),
  .penable (penable),
  .pwrite  (pwrite),
  .paddr   (paddr),
  .pwdata  (pwdata),
  .pwmOut  (pwmOut),
  .irq     (irq),
  .cntVec  (cntVec),
  .ctrlVec (ctrlVec)
);

// File: tb/test_pwm_timer_bank.sv
module test_pwm_timer_bank;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        psel = 1'b0;
  logic        penable = 1'b0;
  logic        pwrite = 1'b0;
  logic [15:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [7:0]  extClk = '0;
  logic [7:0]  pwmOut;
  logic [7:0]  irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_timer_bank i_pwm_timer_bank (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .extClk(extClk),
    .pwmOut(pwmOut), .irq(irq)
  );

  function automatic logic [15:0] chBase(int idx);
    return {idx[2], 9'b0, idx[1:0], 4'b0};
  endfunction

  function automatic int expHigh(int hi, int lo, int periods);
    return (hi < lo) ? (lo - hi) * periods : 0;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic busWr(logic [15:0] a, logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic busRd(logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    #1;
    d = prdata;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic measureHigh(int ch, int n, output int highs);
    highs = 0;
    for (int k = 0; k < n; k++) begin
      if (pwmOut[ch]) highs++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] rd2;
    int highs;
    int seedInit;
    seedInit = $urandom(32'd4711);

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk(pwmOut == 8'h00, "R11 pwm after reset", {24'b0, pwmOut}, 0);
    chk(irq == 8'h00, "R11 irq after reset", {24'b0, irq}, 0);
    busRd(chBase(0) + 16'hC, rd);
    chk(rd == 0, "R11 ctrl after reset", rd, 0);

    // R1 address map
    busWr(chBase(5) + 16'h4, 32'h55);
    busRd(chBase(5) + 16'h4, rd);
    chk(rd == 32'h55, "R1 ch5 duty readback", rd, 32'h55);
    busRd(chBase(1) + 16'h4, rd);
    chk(rd == 0, "R1 ch1 duty untouched", rd, 0);
    busRd(16'h8054, rd);
    chk(rd == 0, "R1 out-of-window read", rd, 0);
    busWr(16'h8044, 32'h77);
    busRd(chBase(5) + 16'h4, rd);
    chk(rd == 32'h55, "R1 out-of-window write ignored", rd, 32'h55);

    // R2 control readback masking
    busWr(chBase(0) + 16'hC, 32'hFFFF_FF36);
    busRd(chBase(0) + 16'hC, rd);
    chk(rd == 32'h36, "R2 ctrl bits 31:8 dropped", rd, 32'h36);
    busWr(chBase(0) + 16'hC, 0);

    // R5 counter load
    busWr(chBase(6), 32'hDEAD_BEEF);
    busRd(chBase(6), rd);
    chk(rd == 32'hDEAD_BEEF, "R5 counter load", rd, 32'hDEAD_BEEF);

    // R3 R4 directed corners then random duty/period
    begin
      int hiL[4] = '{0, 5, 7, 9};
      int loL[4] = '{1, 5, 12, 4};
      for (int t = 0; t < 4; t++) begin
        busWr(chBase(3) + 16'hC, 0);
        busWr(chBase(3) + 16'h4, hiL[t]);
        busWr(chBase(3) + 16'h8, loL[t]);
        busWr(chBase(3), 0);
        busWr(chBase(3) + 16'hC, 32'h09);
        measureHigh(3, 2 * loL[t], highs);
        chk(highs == expHigh(hiL[t], loL[t], 2), "R4 directed high time", highs,
            expHigh(hiL[t], loL[t], 2));
      end
      busWr(chBase(3) + 16'hC, 0);
    end
    for (int t = 0; t < 24; t++) begin
      int ch;
      int lo;
      int hi;
      ch = int'($urandom % 8);
      lo = 1 + int'($urandom % 40);
      hi = int'($urandom % (lo + 3));
      busWr(chBase(ch) + 16'hC, 0);
      busWr(chBase(ch) + 16'h4, hi);
      busWr(chBase(ch) + 16'h8, lo);
      busWr(chBase(ch), 0);
      busWr(chBase(ch) + 16'hC, 32'h09);
      measureHigh(ch, 2 * lo, highs);
      chk(highs == expHigh(hi, lo, 2), "R3 R4 random high time", highs, expHigh(hi, lo, 2));
      busWr(chBase(ch) + 16'hC, 0);
    end

    // R7 R8 single-run with interrupt, period 10
    busWr(chBase(2) + 16'h4, 3);
    busWr(chBase(2) + 16'h8, 10);
    busWr(chBase(2), 0);
    busWr(chBase(2) + 16'hC, 32'h39);
    for (int k = 0; k <= 10; k++) begin
      if (k == 9)  chk(irq[2] == 1'b0, "R8 irq low before period end", {31'b0, irq[2]}, 0);
      if (k == 10) chk(irq[2] == 1'b1, "R8 irq at period end", {31'b0, irq[2]}, 1);
      @(negedge clk);
    end
    busRd(chBase(2) + 16'hC, rd);
    chk(rd == 32'h78, "R7 enable cleared, pending set", rd, 32'h78);
    busRd(chBase(2), rd);
    chk(rd == 0, "R7 counter holds at zero", rd, 0);
    busWr(chBase(2) + 16'hC, 32'h38);
    chk(irq[2] == 1'b0, "R8 pending cleared by write 0", {31'b0, irq[2]}, 0);
    busWr(chBase(2) + 16'hC, 32'h78);
    busRd(chBase(2) + 16'hC, rd);
    chk(rd == 32'h38, "R8 write 1 cannot set pending", rd, 32'h38);
    chk(irq[2] == 1'b0, "R8 irq stays low", {31'b0, irq[2]}, 0);
    busWr(chBase(2) + 16'hC, 0);

    // R6 stop
    busWr(chBase(4) + 16'h4, 0);
    busWr(chBase(4) + 16'h8, 100);
    busWr(chBase(4), 0);
    busWr(chBase(4) + 16'hC, 32'h29);
    repeat (7) @(negedge clk);
    busWr(chBase(4) + 16'hC, 0);
    chk(pwmOut[4] == 1'b0, "R6 pin low after stop", {31'b0, pwmOut[4]}, 0);
    busRd(chBase(4), rd);
    repeat (5) @(negedge clk);
    busRd(chBase(4), rd2);
    chk(rd == rd2 && rd != 0, "R6 counter holds", rd2, rd);

    // R9 counter clear bit
    busWr(chBase(4) + 16'hC, 32'h89);
    repeat (5) @(negedge clk);
    busWr(chBase(4), 32'h1234);
    repeat (2) @(negedge clk);
    busRd(chBase(4), rd);
    chk(rd == 0, "R9 counter forced to zero", rd, 0);
    busWr(chBase(4) + 16'hC, 0);

    // R10 external clock, rising then falling edges
    busWr(chBase(7) + 16'h8, 1000);
    busWr(chBase(7), 0);
    busWr(chBase(7) + 16'hC, 32'h03);
    repeat (8) @(negedge clk);
    busRd(chBase(7), rd);
    chk(rd == 0, "R10 no bus-clock ticks", rd, 0);
    for (int p = 0; p < 5; p++) begin
      extClk[7] = 1'b1; repeat (4) @(negedge clk);
      extClk[7] = 1'b0; repeat (4) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    busRd(chBase(7), rd);
    chk(rd == 5, "R10 rising-edge count", rd, 5);
    busWr(chBase(7) + 16'hC, 0);
    busWr(chBase(7), 0);
    busWr(chBase(7) + 16'hC, 32'h07);
    for (int p = 0; p < 3; p++) begin
      extClk[7] = 1'b1; repeat (4) @(negedge clk);
      extClk[7] = 1'b0; repeat (4) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    busRd(chBase(7), rd);
    chk(rd == 3, "R10 falling-edge count", rd, 3);
    busWr(chBase(7) + 16'hC, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule